// File: doc/BRIEF.md
# Next-PC and Control-Transfer Unit

This block works out where a 64-bit machine with fixed 32-bit instructions fetches next. Each cycle it takes the current program counter, a decoded control-flow code, the 26-bit jump field, the 16-bit branch displacement and one register operand with its index. From these it produces the following program counter. For the two linking jump kinds it also raises a write request that stores the return address in register 31.

The same block decides a conditional register move. A source value is written to a destination register only when a tested register holds zero. Register index 0 is always treated as holding zero, whatever value sits on the operand bus. As a result, a zero test on index 0 always succeeds and a register jump through index 0 goes to address 0.

All outputs are registered once. A decision taken from the inputs sampled at one rising edge appears at the outputs right after that edge. A synchronous active-low reset puts the program counter output at a parameterised start address and clears both write requests.

Top module: `nxpc_unit`

## Requirements
- R1: While reset is held low at a rising edge, the next-PC output becomes RST_PC (default 0) and both write-enable outputs become 0.
- R2: Outputs follow the inputs sampled at the previous rising edge. For flow code 0 (none) and the unused code 7, the next PC is PC+4.
- R3: Flow code 1 (jump): the next PC keeps PC bits 63..28 and takes the jump field in bits 27..2, with bits 1..0 set to zero.
- R4: Flow code 2 (jump-and-link) forms the same target as R3 and also requests the link write.
- R5: Flow code 3 (register jump) takes the next PC from the effective register operand. Flow code 4 (register jump-and-link) does the same and also requests the link write.
- R6: The link write enable is 1 only for codes 2 and 4. The link address is then 31 and the link data is PC+4.
- R7: Flow code 5 (branch-if-zero) goes to PC+4 plus the sign-extended displacement times 4 when the effective operand is zero. Otherwise it goes to PC+4.
- R8: Flow code 6 (branch-if-nonzero) goes to the branch target when the effective operand is nonzero. Otherwise it goes to PC+4.
- R9: A register index of 0 makes the effective value zero whatever the value bus carries. This applies to the branch/register-jump operand and to the move test operand.
- R10: When the move request is 1 and the effective test value is zero, the move write enable is 1, the move address equals the destination index and the move data equals the source value.
- R11: When the move request is 0, or the effective test value is nonzero, the move write enable is 0.
- R12: Displacement 0x7FFF reaches PC+4+131068, and displacement 0x8000 reaches PC+4-131072.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| pc_i | input | 64 | Current program counter |
| cf_op_i | input | 3 | Flow code: 0 none, 1 jump, 2 jump-link, 3 reg jump, 4 reg jump-link, 5 branch-if-zero, 6 branch-if-nonzero, 7 unused |
| jfld_i | input | 26 | Jump target field |
| boff_i | input | 16 | Signed branch word displacement |
| rs_idx_i | input | 5 | Index of the branch / register-jump operand |
| rs_val_i | input | 64 | Value of that operand |
| cmov_i | input | 1 | Conditional move requested |
| tst_idx_i | input | 5 | Index of the move's test register |
| tst_val_i | input | 64 | Value of the test register |
| mv_src_i | input | 64 | Value to move |
| mv_dst_i | input | 5 | Destination index of the move |
| npc_o | output | 64 | Next program counter |
| link_we_o | output | 1 | Link write request |
| link_addr_o | output | 5 | Link register index (31) |
| link_data_o | output | 64 | Return address PC+4 |
| mv_we_o | output | 1 | Move write request |
| mv_addr_o | output | 5 | Move destination index |
| mv_data_o | output | 64 | Move data |

## Verification
The only state is the output stage, so any internal fault shows up on the ports one edge after the offending input. A wrong zero detector would send a branch to the wrong one of its two addresses. It would also raise or drop the move write, and a wrong index-0 override would do the same. A bad sign extension or field splice gives a wrong next PC at once. The sweeps therefore cover every flow code against several PCs, every displacement extreme, zero, one and top-bit operand values, and index 0 against a nonzero index, comparing after every single edge.

// File: rtl/nxpc_pkg.sv
// Shared flow-code encoding for the next-PC unit.
// Assumes the decoder upstream supplies one of these 3-bit codes per instruction.
package nxpc_pkg;
    typedef enum logic [2:0] {
        CF_NONE = 3'd0,
        CF_J    = 3'd1,
        CF_JAL  = 3'd2,
        CF_JR   = 3'd3,
        CF_JALR = 3'd4,
        CF_BZ   = 3'd5,
        CF_BNZ  = 3'd6,
        CF_RSV  = 3'd7
    } cf_op_e;
endpackage

// File: rtl/nxpc_operand.sv
// Effective register operand: forces index 0 to read as zero and flags a zero value.
// Assumes the register file may present any value on the bus for index 0.
module nxpc_operand #(
    parameter int XLEN = 64,
    parameter int RIDX = 5
) (
    input  logic [RIDX-1:0] idx_i,
    input  logic [XLEN-1:0] val_i,
    output logic [XLEN-1:0] eff_o,
    output logic            zero_o
);
    // Apply the hard-wired zero register, then test the result.
    always_comb begin
        eff_o  = (idx_i == '0) ? '0 : val_i;
        zero_o = (eff_o == '0);
    end
endmodule

// File: rtl/nxpc_target.sv
// Candidate target generator: sequential, field jump and relative branch addresses.
// Assumes word-aligned fixed 4-byte instructions.
module nxpc_target #(
    parameter int XLEN = 64,
    parameter int JFLD = 26,
    parameter int BOFF = 16
) (
    input  logic [XLEN-1:0] pc_i,
    input  logic [JFLD-1:0] jfld_i,
    input  logic [BOFF-1:0] boff_i,
    output logic [XLEN-1:0] seq_o,
    output logic [XLEN-1:0] jtgt_o,
    output logic [XLEN-1:0] btgt_o
);
    localparam int JSPAN = JFLD + 2;
    localparam int SEXT  = XLEN - BOFF - 2;

    logic [XLEN-1:0] disp;

    // Build all three candidates in parallel.
    always_comb begin
        seq_o  = pc_i + XLEN'(4);
        jtgt_o = {pc_i[XLEN-1:JSPAN], jfld_i, 2'b00};
        disp   = {{SEXT{boff_i[BOFF-1]}}, boff_i, 2'b00};
        btgt_o = seq_o + disp;
    end
endmodule

// File: rtl/nxpc_select.sv
// Next-PC selection and link request from the flow code and the zero test.
// Assumes reserved codes behave as sequential flow.
module nxpc_select
    import nxpc_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  cf_op_e          op_i,
    input  logic [XLEN-1:0] seq_i,
    input  logic [XLEN-1:0] jtgt_i,
    input  logic [XLEN-1:0] btgt_i,
    input  logic [XLEN-1:0] reg_i,
    input  logic            reg_zero_i,
    output logic [XLEN-1:0] npc_o,
    output logic            link_o
);
    // Pick the next address and decide whether a return address is saved.
    always_comb begin
        npc_o  = seq_i;
        link_o = 1'b0;
        case (op_i)
            CF_J:    npc_o = jtgt_i;
            CF_JAL:  begin npc_o = jtgt_i; link_o = 1'b1; end
            CF_JR:   npc_o = reg_i;
            CF_JALR: begin npc_o = reg_i; link_o = 1'b1; end
            CF_BZ:   npc_o = reg_zero_i ? btgt_i : seq_i;
            CF_BNZ:  npc_o = reg_zero_i ? seq_i : btgt_i;
            default: npc_o = seq_i;
        endcase
    end
endmodule

// File: rtl/nxpc_unit.sv
// Top of the next-PC and control-transfer unit, with a registered output stage.
// Assumes one decoded instruction per cycle; outputs reflect the previous edge's inputs.
module nxpc_unit
    import nxpc_pkg::*;
#(
    parameter int          XLEN     = 64,
    parameter int          JFLD     = 26,
    parameter int          BOFF     = 16,
    parameter int          RIDX     = 5,
    parameter int          LINK_REG = 31,
    parameter logic [63:0] RST_PC   = 64'h0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [XLEN-1:0] pc_i,
    input  logic [2:0]      cf_op_i,
    input  logic [JFLD-1:0] jfld_i,
    input  logic [BOFF-1:0] boff_i,
    input  logic [RIDX-1:0] rs_idx_i,
    input  logic [XLEN-1:0] rs_val_i,
    input  logic            cmov_i,
    input  logic [RIDX-1:0] tst_idx_i,
    input  logic [XLEN-1:0] tst_val_i,
    input  logic [XLEN-1:0] mv_src_i,
    input  logic [RIDX-1:0] mv_dst_i,
    output logic [XLEN-1:0] npc_o,
    output logic            link_we_o,
    output logic [RIDX-1:0] link_addr_o,
    output logic [XLEN-1:0] link_data_o,
    output logic            mv_we_o,
    output logic [RIDX-1:0] mv_addr_o,
    output logic [XLEN-1:0] mv_data_o
);
    localparam int NOPND = 2;

    logic [XLEN-1:0] opnd_val [NOPND];
    logic [RIDX-1:0] opnd_idx [NOPND];
    logic [XLEN-1:0] opnd_eff [NOPND];
    logic            opnd_zero[NOPND];

    logic [XLEN-1:0] seq, jtgt, btgt, npc_d;
    logic            link_d;
    cf_op_e          op;

    // Route the two tested operands: 0 is the branch/jump operand, 1 the move test.
    always_comb begin
        opnd_val[0] = rs_val_i;
        opnd_idx[0] = rs_idx_i;
        opnd_val[1] = tst_val_i;
        opnd_idx[1] = tst_idx_i;
        op          = cf_op_e'(cf_op_i);
    end

    for (genvar g = 0; g < NOPND; g++) begin : g_opnd
        nxpc_operand #(.XLEN(XLEN), .RIDX(RIDX)) u_opnd (
            .idx_i  (opnd_idx[g]),
            .val_i  (opnd_val[g]),
            .eff_o  (opnd_eff[g]),
            .zero_o (opnd_zero[g])
        );
    end

    nxpc_target #(.XLEN(XLEN), .JFLD(JFLD), .BOFF(BOFF)) u_tgt (
        .pc_i   (pc_i),
        .jfld_i (jfld_i),
        .boff_i (boff_i),
        .seq_o  (seq),
        .jtgt_o (jtgt),
        .btgt_o (btgt)
    );

    nxpc_select #(.XLEN(XLEN)) u_sel (
        .op_i       (op),
        .seq_i      (seq),
        .jtgt_i     (jtgt),
        .btgt_i     (btgt),
        .reg_i      (opnd_eff[0]),
        .reg_zero_i (opnd_zero[0]),
        .npc_o      (npc_d),
        .link_o     (link_d)
    );

    // Output stage: reset state, else capture this cycle's decisions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            npc_o       <= XLEN'(RST_PC);
            link_we_o   <= 1'b0;
            link_addr_o <= RIDX'(LINK_REG);
            link_data_o <= '0;
            mv_we_o     <= 1'b0;
            mv_addr_o   <= '0;
            mv_data_o   <= '0;
        end else begin
            npc_o       <= npc_d;
            link_we_o   <= link_d;
            link_addr_o <= RIDX'(LINK_REG);
            link_data_o <= seq;
            mv_we_o     <= cmov_i && opnd_zero[1];
            mv_addr_o   <= mv_dst_i;
            mv_data_o   <= mv_src_i;
        end
    end
endmodule

// File: rtl/nxpc_chk.sv
// Property checker for nxpc_unit, attached by bind.
module nxpc_chk #(
    parameter int XLEN     = 64,
    parameter int JFLD     = 26,
    parameter int RIDX     = 5,
    parameter int LINK_REG = 31
) (
    input logic            clk,
    input logic            rst_n,
    input logic [XLEN-1:0] pc_i,
    input logic [2:0]      cf_op_i,
    input logic [RIDX-1:0] rs_idx_i,
    input logic            cmov_i,
    input logic [RIDX-1:0] tst_idx_i,
    input logic [XLEN-1:0] tst_val_i,
    input logic [XLEN-1:0] npc_o,
    input logic            link_we_o,
    input logic [RIDX-1:0] link_addr_o,
    input logic [XLEN-1:0] link_data_o,
    input logic            mv_we_o
);
    localparam int JSPAN = JFLD + 2;

    // R2: sequential flow advances by one instruction
    a_r2_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cf_op_i) == 3'd0) |-> npc_o == $past(pc_i) + XLEN'(4));

    // R3: a field jump keeps the upper PC bits and is word aligned
    a_r3_jump_upper: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cf_op_i) == 3'd1) |->
        (npc_o[XLEN-1:JSPAN] == $past(pc_i[XLEN-1:JSPAN]) && npc_o[1:0] == 2'b00));

    // R6: link writes target the link register with the return address
    a_r6_link_value: assert property (@(posedge clk) disable iff (!rst_n)
        link_we_o |-> (link_addr_o == RIDX'(LINK_REG) && link_data_o == $past(pc_i) + XLEN'(4)));

    // R6: link writes come only from the two linking codes
    a_r6_link_source: assert property (@(posedge clk) disable iff (!rst_n)
        link_we_o |-> ($past(cf_op_i) == 3'd2 || $past(cf_op_i) == 3'd4));

    // R9: a nonzero-branch on index 0 never leaves the sequential path
    a_r9_zero_reg: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cf_op_i) == 3'd6 && $past(rs_idx_i) == '0) |->
        npc_o == $past(pc_i) + XLEN'(4));

    // R11: no move write without a request and a zero test
    a_r11_cmov_off: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (!$past(cmov_i) ||
         ($past(tst_idx_i) != '0 && $past(tst_val_i) != '0))) |-> !mv_we_o);
endmodule

bind nxpc_unit nxpc_chk #(
    .XLEN(XLEN), .JFLD(JFLD), .RIDX(RIDX), .LINK_REG(LINK_REG)
) u_chk (.*);

// File: tb/sim_nxpc_unit.sv
// Self-checking sweep bench for nxpc_unit.
module sim_nxpc_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] pc_i = '0;
    logic [2:0]  cf_op_i = '0;
    logic [25:0] jfld_i = '0;
    logic [15:0] boff_i = '0;
    logic [4:0]  rs_idx_i = '0;
    logic [63:0] rs_val_i = '0;
    logic        cmov_i = 1'b0;
    logic [4:0]  tst_idx_i = '0;
    logic [63:0] tst_val_i = '0;
    logic [63:0] mv_src_i = '0;
    logic [4:0]  mv_dst_i = '0;
    logic [63:0] npc_o, link_data_o, mv_data_o;
    logic        link_we_o, mv_we_o;
    logic [4:0]  link_addr_o, mv_addr_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    nxpc_unit u0 (.*);

    // Compare one value and log a failure with its requirement tag.
    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Expected next PC, computed from the requirements.
    function automatic logic [63:0] model_npc(input logic [2:0] op, input logic [63:0] pc,
        input logic [25:0] j, input logic [15:0] b, input logic [4:0] idx, input logic [63:0] v);
        logic [63:0] seq, eff, bt;
        seq = pc + 64'd4;
        eff = (idx == 5'd0) ? 64'd0 : v;
        bt  = seq + ({{48{b[15]}}, b} * 64'd4);
        case (op)
            3'd1, 3'd2: return (pc & ~64'h0FFF_FFFF) | ({38'd0, j} << 2);
            3'd3, 3'd4: return eff;
            3'd5:       return (eff == 0) ? bt : seq;
            3'd6:       return (eff != 0) ? bt : seq;
            default:    return seq;
        endcase
    endfunction

    function automatic string op_tag(input logic [2:0] op);
        case (op)
            3'd1: return "R3";
            3'd2: return "R4";
            3'd3, 3'd4: return "R5";
            3'd5: return "R7";
            3'd6: return "R8";
            default: return "R2";
        endcase
    endfunction

    // Apply inputs between edges, then sample one edge later.
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    initial begin
        logic [63:0] pcs [4];
        logic [63:0] vals[3];
        logic [15:0] offs[5];
        logic [25:0] jfs [3];
        pcs[0] = 64'h0;                    pcs[1] = 64'h0000_0000_0040_0000;
        pcs[2] = 64'hFFFF_FFFF_FFFF_FFF0;  pcs[3] = 64'h1234_5678_9ABC_DEF0;
        vals[0] = 64'h0; vals[1] = 64'h1; vals[2] = 64'h8000_0000_0000_0000;
        offs[0] = 16'h0000; offs[1] = 16'h0001; offs[2] = 16'h7FFF;
        offs[3] = 16'h8000; offs[4] = 16'hFFFF;
        jfs[0] = 26'h0; jfs[1] = 26'h3FF_FFFF; jfs[2] = 26'h155_5555;

        // R1: reset state with busy inputs
        pc_i = 64'hDEAD_BEEF_0000_1000; cf_op_i = 3'd2; cmov_i = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 npc", npc_o, 64'h0);
        chk("R1 link_we", {63'd0, link_we_o}, 64'd0);
        chk("R1 mv_we", {63'd0, mv_we_o}, 64'd0);
        @(negedge clk);
        rst_n = 1'b1; cf_op_i = 3'd0; cmov_i = 1'b0;
        @(negedge clk);

        // R2..R9: every flow code over PCs, operands, indices and displacements
        for (int p = 0; p < 4; p++)
            for (int o = 0; o < 8; o++)
                for (int v = 0; v < 3; v++)
                    for (int ix = 0; ix < 2; ix++)
                        for (int f = 0; f < 5; f++) begin
                            pc_i = pcs[p]; cf_op_i = 3'(o); rs_val_i = vals[v];
                            rs_idx_i = (ix == 0) ? 5'd0 : 5'd9;
                            boff_i = offs[f]; jfld_i = jfs[(p + f) % 3];
                            step();
                            chk((ix == 0 && (o == 5 || o == 6 || o == 3)) ? "R9" : op_tag(3'(o)),
                                npc_o, model_npc(3'(o), pcs[p], jfs[(p + f) % 3], offs[f],
                                                 rs_idx_i, vals[v]));
                            chk("R6 link_we", {63'd0, link_we_o}, {63'd0, (o == 2 || o == 4)});
                            if (o == 2 || o == 4) begin
                                chk("R6 link_addr", {59'd0, link_addr_o}, 64'd31);
                                chk("R6 link_data", link_data_o, pcs[p] + 64'd4);
                            end
                            @(negedge clk);
                        end

        // R12: displacement extremes from a fixed PC
        pc_i = 64'h0000_0000_1000_0000; rs_idx_i = 5'd0; cf_op_i = 3'd5;
        boff_i = 16'h7FFF; step();
        chk("R12 max fwd", npc_o, 64'h0000_0000_1000_0004 + 64'd131068);
        @(negedge clk);
        boff_i = 16'h8000; step();
        chk("R12 max back", npc_o, 64'h0000_0000_1000_0004 - 64'd131072);
        @(negedge clk);
        cf_op_i = 3'd0;

        // R10, R11, R9: conditional move over request, test index and test value
        for (int c = 0; c < 2; c++)
            for (int ix = 0; ix < 2; ix++)
                for (int v = 0; v < 3; v++) begin
                    cmov_i = c[0]; tst_idx_i = (ix == 0) ? 5'd0 : 5'd7;
                    tst_val_i = vals[v]; mv_src_i = 64'hA5A5_0000_0000_0000 | 64'(v * 4 + ix);
                    mv_dst_i = 5'(3 + v);
                    step();
                    if (c == 1 && (ix == 0 || v == 0)) begin
                        chk((ix == 0) ? "R9 mv_we" : "R10 mv_we", {63'd0, mv_we_o}, 64'd1);
                        chk("R10 mv_addr", {59'd0, mv_addr_o}, 64'(3 + v));
                        chk("R10 mv_data", mv_data_o, 64'hA5A5_0000_0000_0000 | 64'(v * 4 + ix));
                    end else begin
                        chk("R11 mv_we", {63'd0, mv_we_o}, 64'd0);
                    end
                    @(negedge clk);
                end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule